// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects seven event inputs into a single level-sensitive interrupt line for a parent controller. Each source is edge-detected. A rising edge latches the source's bit in a cause register. A mask register decides which latched bits may drive the output. Software reaches both registers through a simple register port made of an address, a write enable, write data and combinational read data.

The cause register is plain read-write and is not write-one-to-clear. Whatever value is written is the value the register holds, so writing a 1 raises a software interrupt and writing a 0 clears one. To service an interrupt, software reads the cause register and writes back a value with the handled bits cleared. A hardware edge that arrives in the same cycle as that write is never lost: the event takes priority for its bit.

Top module: `irq_cause_mask`

## Requirements
- R1: Reset (active-low `rst_n`) clears the cause register and the mask register to 0, and `irq_out` is low after reset.
- R2: A write to address 0x50 loads cause bits 6..0 with write-data bits 6..0, so 1s set bits and 0s clear them. With no write and no new edge, the cause register holds its value.
- R3: A rising edge on `src_in[i]` (0 in the previous cycle, 1 in this one) sets cause bit i at the next clock. A source held high sets its bit only once, so once software clears the bit it stays 0.
- R4: When a rising edge on `src_in[i]` and a write to the cause register happen in the same cycle, cause bit i ends up 1 whatever value was written to that bit.
- R5: A write to address 0x54 loads mask bits 6..0. A mask bit of 1 enables its source, and a mask bit of 0 blocks it.
- R6: `irq_out` is high exactly while some cause bit and the matching mask bit are both 1. It follows the registers with no further delay.
- R7: Bits 31..7 of both registers read as 0, and writes to those bits have no effect.
- R8: Reads of any address other than 0x50 or 0x54 return 0, and writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | 7 | Event sources, one per cause bit |
| irq_out | output | 1 | Level interrupt to the parent controller |

## Verification
A cause bit latched wrongly shows up in two places. It is visible on the cause read port in the cycle after the clock edge that should have set or cleared it. If that bit is enabled, it also shows as a wrong level on `irq_out` in the same cycle. A stuck or missing edge detector shows up only when a source stays high across a software clear, so the bench checks the held-source case and the same-cycle event-and-write case at the next clock. A wrong mask state shows up on `irq_out` as soon as a cause bit is set under that mask.

// File: rtl/irq_cause_mask.sv
module irq_cause_mask #(
  parameter int NSRC = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFF = 8'h50,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_out
);
  logic [NSRC-1:0] cause_q, mask_q, src_q, rise;
  logic hit_cause, hit_mask;
  logic unused_hi;

  assign rise      = src_in & ~src_q;
  assign hit_cause = bus_we && (bus_addr == CAUSE_OFF);
  assign hit_mask  = bus_we && (bus_addr == MASK_OFF);
  assign unused_hi = ^bus_wdata[DATA_W-1:NSRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      src_q   <= '0;
    end else begin
      src_q   <= src_in;
      // hardware edge wins over a same-cycle write
      cause_q <= (hit_cause ? bus_wdata[NSRC-1:0] : cause_q) | rise;
      if (hit_mask) mask_q <= bus_wdata[NSRC-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CAUSE_OFF)     bus_rdata[NSRC-1:0] = cause_q;
    else if (bus_addr == MASK_OFF) bus_rdata[NSRC-1:0] = mask_q;
  end

  assign irq_out = |(cause_q & mask_q);
endmodule

module irq_cause_mask_chk #(
  parameter int NSRC = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFF = 8'h50,
  parameter logic [ADDR_W-1:0] MASK_OFF  = 8'h54
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NSRC-1:0]   wlow,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NSRC-1:0]   src_in,
  input logic              irq_out,
  input logic [NSRC-1:0]   cause,
  input logic [NSRC-1:0]   mask
);
  logic [NSRC-1:0] prev, edg;
  always_ff @(posedge clk) prev <= rst_n ? src_in : '0;
  assign edg = src_in & ~prev;

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & $past(edg)) == $past(edg)));                                 // R3
  AST_EDGE_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CAUSE_OFF && edg != '0) |=> ((cause & $past(edg)) == $past(edg))); // R4
  AST_CAUSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == CAUSE_OFF && edg == '0) |=> (cause == $past(wlow)));     // R2
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && bus_addr == CAUSE_OFF) && edg == '0) |=> $stable(cause));          // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == MASK_OFF) |=> (mask == $past(wlow)));                    // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_out);                                                     // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NSRC] == '0);                                                // R7
  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != CAUSE_OFF && bus_addr != MASK_OFF) |-> (bus_rdata == '0));         // R8
endmodule

bind irq_cause_mask irq_cause_mask_chk #(
  .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .CAUSE_OFF(CAUSE_OFF), .MASK_OFF(MASK_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .wlow(bus_wdata[NSRC-1:0]), .bus_rdata(bus_rdata), .src_in(src_in),
  .irq_out(irq_out), .cause(cause_q), .mask(mask_q)
);

// File: tb/irq_cause_mask_test.sv
`timescale 1ns/1ps
module irq_cause_mask_test;
  localparam logic [7:0] CA = 8'h50, MA = 8'h54;
  logic clk = 0, rst_n = 0, we = 0, irq;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [6:0] src = 0;
  logic [6:0] m_cause = 0, m_mask = 0, m_prev = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_cause_mask uut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src), .irq_out(irq));

  function automatic logic [6:0] next_cause(logic [6:0] c, logic w, logic [7:0] a,
                                            logic [31:0] d, logic [6:0] s, logic [6:0] p);
    logic [6:0] e = s & ~p;
    return ((w && a == CA) ? d[6:0] : c) | e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic [7:0] a, logic [31:0] d, logic [6:0] s, string req);
    @(negedge clk);
    we = w; addr = a; wdata = d; src = s;
    @(posedge clk);
    m_cause = next_cause(m_cause, w, a, d, s, m_prev);
    if (w && a == MA) m_mask = d[6:0];
    m_prev = s;
    @(negedge clk);
    we = 0;
    check({req, " irq"}, {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    addr = a; we = 0;
    #0.5;
    check(req, rdata, exp);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    rd(CA, 0, "R1 cause reset"); rd(MA, 0, "R1 mask reset");
    check("R1 irq reset", {31'd0, irq}, 0);

    cyc(1, MA, 32'h08, 0, "R5");
    rd(MA, 32'h08, "R5 mask readback");
    cyc(1, CA, 32'h08, 0, "R2 sw set");
    rd(CA, 32'h08, "R2 sw set");
    check("R6 irq high", {31'd0, irq}, 1);
    cyc(1, CA, 32'h00, 0, "R2 clear");
    check("R6 irq low after clear", {31'd0, irq}, 0);

    cyc(1, MA, 32'h7F, 0, "R5");
    cyc(0, 0, 0, 7'h04, "R3 edge");
    rd(CA, 32'h04, "R3 edge sets bit2");
    cyc(0, 0, 0, 7'h04, "R3 hold");
    cyc(1, CA, 0, 7'h04, "R3 clear while held");
    rd(CA, 0, "R3 held source sets once");
    cyc(0, 0, 0, 7'h04, "R3 still held");
    rd(CA, 0, "R3 no re-latch");

    cyc(0, 0, 0, 0, "R4 prep");
    cyc(1, CA, 32'h01, 7'h24, "R4 collide");
    rd(CA, 32'h25, "R4 event beats write");

    cyc(1, MA, 32'h00, 0, "R5 mask all");
    check("R5 masked irq", {31'd0, irq}, 0);
    rd(CA, 32'h25, "R5 cause kept when masked");

    cyc(1, CA, 32'hFFFF_FFFF, 0, "R7");
    rd(CA, 32'h7F, "R7 cause upper zero");
    cyc(1, MA, 32'hFFFF_FF80, 0, "R7");
    rd(MA, 32'h00, "R7 mask upper ignored");

    cyc(1, 8'h58, 32'h0, 0, "R8");
    cyc(1, 8'h00, 32'h0, 0, "R8");
    rd(8'h58, 0, "R8 other addr reads 0");
    rd(CA, 32'h7F, "R8 cause untouched");
    rd(MA, 32'h00, "R8 mask untouched");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      case ($urandom % 4)
        0: a = CA; 1: a = MA; 2: a = 8'h58; default: a = 8'h10;
      endcase
      cyc(($urandom % 3) == 0, a, $urandom, 7'($urandom), "R6 random");
      if (i % 8 == 0) begin
        rd(CA, {25'd0, m_cause}, "R2 random cause");
        rd(MA, {25'd0, m_mask}, "R5 random mask");
      end
    end

    cyc(1, CA, 0, 0, "R2 final");
    cyc(1, MA, 0, 0, "R5 final");
    rd(CA, 0, "R2 all cleared"); rd(MA, 0, "R5 all masked");
    check("R6 final irq", {31'd0, irq}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule